// File: doc/BRIEF.md
# Rotating Serial Word Copier

This block copies a word from one shift register into another, one bit per clock. Both registers shift toward the least significant end. On each shift the bit leaving the bottom of the source is fed back into the top of the source and also into the top of the destination. After a full transfer of N shifts, the destination holds the source word and the source is back at its starting value.

Either register can be loaded in parallel at any time, and both are always visible as parallel outputs. A start pulse begins a transfer. A shift counter ends the transfer after exactly N shifts, and a one-cycle done pulse marks the end. Shifting is gated by a synchronous enable; the clock is never gated. An active-low asynchronous reset clears both registers, the counter and the flags.

Top module: `serial_copy_unit`

## Requirements
- R1: While reset is asserted and after its release, both registers read zero and busy and done are low.
- R2: A high loadSrc (or loadDst) on a clock edge writes srcIn (or dstIn) into that register. The two loads act independently.
- R3: start, sampled on an edge while idle with no load present, raises busy on that edge. The next N edges each perform exactly one shift, and busy stays high for exactly those N cycles.
- R4: Each shift moves both registers right by one bit. The old source bit 0 enters bit N-1 of both the source and the destination.
- R5: After an uninterrupted transfer the destination equals the source word from before the transfer, and the source equals its value from before the transfer. For N=4, source 1011 and destination 0011 step through 1101/1001, 1110/1100, 0111/0110, 1011/1011.
- R6: done goes high for exactly one cycle on the edge that performs the Nth shift, and busy falls on that same edge.
- R7: start while busy has no effect. The transfer still ends after N shifts in total.
- R8: A load takes priority over shifting. A load during a transfer aborts it: busy falls, no shift happens on that edge, the loaded value appears, and done does not pulse.
- R9: When no load and no shift occurs on an edge, both registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| loadSrc | input | 1 | Parallel load strobe for the source register |
| loadDst | input | 1 | Parallel load strobe for the destination register |
| srcIn | input | N | Parallel data for the source register |
| dstIn | input | N | Parallel data for the destination register |
| start | input | 1 | Begin a transfer when idle |
| srcOut | output | N | Source register contents |
| dstOut | output | N | Destination register contents |
| busy | output | 1 | High while a transfer is in progress |
| done | output | 1 | One-cycle pulse after the final shift |

## Verification
The assertions assume that all inputs are synchronous to clk and stay stable across the rising edge. They also assume that start and the load strobes may arrive in any combination, including together and during a transfer. The stimulus changes inputs only on the falling edge. It draws start and both loads from a fixed-seed random stream at rates that let many transfers run to completion while others are cut short by loads or receive repeated start pulses. Directed sequences cover the worked 4-bit example, a start issued during a transfer, and an abort by load.

// File: rtl/sct_pkg.sv
package sct_pkg;

  // Strobes driven by the control unit into the datapath
  typedef struct packed {
    logic loadSrc;
    logic loadDst;
    logic shiftEn;
  } ctlStrobes_t;

endpackage

// File: rtl/sct_ctrl.sv
module sct_ctrl
  import sct_pkg::*;
#(
  parameter int N = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadSrc,
  input  logic        loadDst,
  input  logic        start,
  output ctlStrobes_t strobes,
  output logic        busy,
  output logic        done
);

  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] shiftCnt;
  logic          anyLoad;
  logic          lastShift;

  assign anyLoad   = loadSrc | loadDst;
  assign lastShift = busy && !anyLoad && (shiftCnt == LAST);

  assign strobes.loadSrc = loadSrc;
  assign strobes.loadDst = loadDst;
  assign strobes.shiftEn = busy && !anyLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      shiftCnt <= '0;
    end else begin
      done <= lastShift;
      if (anyLoad) begin
        busy     <= 1'b0;
        shiftCnt <= '0;
      end else if (busy) begin
        if (lastShift) begin
          busy     <= 1'b0;
          shiftCnt <= '0;
        end else begin
          shiftCnt <= shiftCnt + 1'b1;
        end
      end else if (start) begin
        busy     <= 1'b1;
        shiftCnt <= '0;
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  done_busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftCnt <= LAST);

  // R8
  load_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadSrc || loadDst) |=> (!busy && !done));

  // R3
  start_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && !loadSrc && !loadDst) |=> busy);

endmodule

// File: rtl/sct_datapath.sv
module sct_datapath
  import sct_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctlStrobes_t  strobes,
  input  logic [N-1:0] srcIn,
  input  logic [N-1:0] dstIn,
  output logic [N-1:0] srcQ,
  output logic [N-1:0] dstQ
);

  logic outBit;
  assign outBit = srcQ[0];

  // Source register: rotate right, bit 0 loops back to the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ <= '0;
    end else if (strobes.loadSrc) begin
      srcQ <= srcIn;
    end else if (strobes.shiftEn && !strobes.loadDst) begin
      srcQ <= {outBit, srcQ[N-1:1]};
    end
  end

  // Destination register: shift right, source bit enters the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dstQ <= '0;
    end else if (strobes.loadDst) begin
      dstQ <= dstIn;
    end else if (strobes.shiftEn && !strobes.loadSrc) begin
      dstQ <= {outBit, dstQ[N-1:1]};
    end
  end

  // R4
  src_rotate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.shiftEn && !strobes.loadSrc && !strobes.loadDst)
      |=> srcQ == {$past(srcQ[0]), $past(srcQ[N-1:1])});

  // R4
  dst_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.shiftEn && !strobes.loadSrc && !strobes.loadDst)
      |=> dstQ == {$past(srcQ[0]), $past(dstQ[N-1:1])});

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.shiftEn && !strobes.loadSrc && !strobes.loadDst)
      |=> ($stable(srcQ) && $stable(dstQ)));

  // R2
  load_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadSrc |=> srcQ == $past(srcIn));

endmodule

// File: rtl/serial_copy_unit.sv
module serial_copy_unit
  import sct_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         loadSrc,
  input  logic         loadDst,
  input  logic [N-1:0] srcIn,
  input  logic [N-1:0] dstIn,
  input  logic         start,
  output logic [N-1:0] srcOut,
  output logic [N-1:0] dstOut,
  output logic         busy,
  output logic         done
);

  ctlStrobes_t strobes;

  sct_ctrl #(.N(N)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadSrc (loadSrc),
    .loadDst (loadDst),
    .start   (start),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  sct_datapath #(.N(N)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .srcIn   (srcIn),
    .dstIn   (dstIn),
    .srcQ    (srcOut),
    .dstQ    (dstOut)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |-> (srcOut == '0 && dstOut == '0 && !busy && !done));

endmodule

// File: tb/serial_copy_unit_tb.sv
`timescale 1ns/1ps
module serial_copy_unit_tb;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         loadSrc = 1'b0, loadDst = 1'b0, start = 1'b0;
  logic [N-1:0] srcIn = '0, dstIn = '0;
  logic [N-1:0] srcOut, dstOut;
  logic         busy, done;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // expected-state model
  logic [N-1:0] srcM = '0, dstM = '0;
  logic         busyM = 1'b0, doneM = 1'b0;
  int           cntM = 0;

  always #10 clk = ~clk;

  serial_copy_unit #(.N(N)) u_dut (
    .clk(clk), .rstN(rstN), .loadSrc(loadSrc), .loadDst(loadDst),
    .srcIn(srcIn), .dstIn(dstIn), .start(start),
    .srcOut(srcOut), .dstOut(dstOut), .busy(busy), .done(done)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] rotR(logic [N-1:0] v);
    return {v[0], v[N-1:1]};
  endfunction

  // Advance the model by one edge from the requirements
  task automatic modelStep();
    logic b;
    if (loadSrc || loadDst) begin           // R8, R2
      if (loadSrc) srcM = srcIn;
      if (loadDst) dstM = dstIn;
      busyM = 0; doneM = 0; cntM = 0;
    end else if (busyM) begin               // R4, R6
      b = srcM[0];
      srcM = rotR(srcM);
      dstM = {b, dstM[N-1:1]};
      cntM++;
      doneM = (cntM == N);
      if (cntM == N) begin busyM = 0; cntM = 0; end
    end else begin                          // R3, R7, R9
      doneM = 0;
      if (start) begin busyM = 1; cntM = 0; end
    end
  endtask

  task automatic compareAll(string tag);
    chk({tag, " src"},  32'(srcOut), 32'(srcM));
    chk({tag, " dst"},  32'(dstOut), 32'(dstM));
    chk({tag, " busy"}, 32'(busy),   32'(busyM));
    chk({tag, " done"}, 32'(done),   32'(doneM));
  endtask

  // Called at a falling edge: drive, step model, compare at next falling edge
  task automatic cycle(bit ls, bit ld, logic [N-1:0] si, logic [N-1:0] di,
                       bit st, string tag);
    loadSrc = ls; loadDst = ld; srcIn = si; dstIn = di; start = st;
    modelStep();
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic idle(string tag);
    cycle(0, 0, '0, '0, 0, tag);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (2) @(negedge clk);
    compareAll("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1 after reset");

    // Worked example R5
    cycle(1, 1, 4'b1011, 4'b0011, 0, "R2 load both");
    cycle(0, 0, '0, '0, 1, "R3 start");
    chk("R3 busy raised", 32'(busy), 1);
    idle("R4 shift1");
    chk("R5 step1", 32'({srcOut, dstOut}), 32'({4'b1101, 4'b1001}));
    idle("R4 shift2");
    chk("R5 step2", 32'({srcOut, dstOut}), 32'({4'b1110, 4'b1100}));
    idle("R4 shift3");
    chk("R5 step3", 32'({srcOut, dstOut}), 32'({4'b0111, 4'b0110}));
    idle("R4 shift4");
    chk("R5 final", 32'({srcOut, dstOut}), 32'({4'b1011, 4'b1011}));
    chk("R6 done high", 32'(done), 1);
    chk("R6 busy low", 32'(busy), 0);
    idle("R6 done drop");
    chk("R6 done one cycle", 32'(done), 0);
    idle("R9 hold");

    // R7: start repeated during transfer
    cycle(1, 1, 4'b0110, 4'b1111, 0, "R2 load");
    cycle(0, 0, '0, '0, 1, "R7 start");
    for (int i = 0; i < N; i++) cycle(0, 0, '0, '0, 1, "R7 start while busy");
    chk("R7 done after N", 32'(done), 1);
    chk("R7 dst copy", 32'(dstOut), 32'(4'b0110));

    // R8: load aborts
    cycle(0, 0, '0, '0, 0, "R8 idle");
    cycle(1, 1, 4'b1001, 4'b0000, 0, "R2 load");
    cycle(0, 0, '0, '0, 1, "R8 start");
    idle("R8 shift");
    cycle(0, 1, '0, 4'b0101, 0, "R8 abort load");
    chk("R8 busy low", 32'(busy), 0);
    idle("R8 no done");
    chk("R8 done stays low", 32'(done), 0);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      bit ls, ld, st;
      ls = ($urandom % 16) == 0;
      ld = ($urandom % 16) == 0;
      st = ($urandom % 4) == 0;
      cycle(ls, ld, N'($urandom), N'($urandom), st, "R3 R4 R6 R8 R9 random");
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule